// File: doc/BRIEF.md
# Predicated Find-First Mask Generator

This block turns a source bit-vector into a mask that marks where the lowest active set bit lies. An optional predicate decides which positions take part. A position whose predicate bit is 0 is inactive. An inactive position is never searched, and it keeps the bit it had in a supplied previous destination value. The "first" bit is the lowest-indexed position that is both active and set in the source. A 2-bit mode picks what is written around that bit: the active positions before it, the positions up to and including it, or only that bit.

The search runs as a parallel prefix-OR over the active source bits, so its depth grows with the logarithm of the width and not with a serial bit scan. The result passes through one register slice, which uses valid/ready on both sides. An input beat is taken when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high when the slice is empty or when its result is taken in the same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged. An upstream source must hold its beat until it is taken.

Top module: `ffm_mask_gen`

## Requirements
- R1: In mode 2'b00 (before-first), every active position below the first active source 1 outputs 1. That position and every active position above it output 0.
- R2: In mode 2'b00, when no active position holds a source 1, every active position outputs 1.
- R3: In mode 2'b01 (including-first), active positions up to and including the first active source 1 output 1, and active positions above it output 0. When no active source 1 exists, every active position outputs 1.
- R4: In mode 2'b10 (only-first), only the first active source 1 outputs 1, so at most one active position is set. When no active source 1 exists, every active position outputs 0.
- R5: In modes 2'b00, 2'b01 and 2'b10, a position whose predicate bit is 0 outputs the matching bit of `in_prev`. A source 1 at such a position has no effect on the search.
- R6: When `in_pred_en` is 0, `in_pred` is ignored and every position is active.
- R7: Mode 2'b11 is reserved and outputs an all-zero mask, including the inactive positions.
- R8: A beat accepted at a clock edge gives `out_valid` high, with its mask, right after that edge.
- R9: `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_mask` stays unchanged.
- R10: While `rst_n` is low, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat can be taken this cycle |
| in_src | input | XLEN | Source bit-vector to search |
| in_pred | input | XLEN | Predicate, 1 marks an active position |
| in_pred_en | input | 1 | 1 applies in_pred, 0 makes every position active |
| in_prev | input | XLEN | Previous destination, used at inactive positions |
| in_mode | input | 2 | 00 before-first, 01 including-first, 10 only-first, 11 reserved |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_mask | output | XLEN | Result mask |

## Verification
A wrong prefix term in the search shows up as a misplaced boundary in `out_mask`. It appears exactly one cycle after the beat that exposes it is accepted, and only for sources whose first active bit lies above the faulty span. So the bench mixes directed vectors with random sources and predicates of varied density. A faulty merge of inactive positions shows up as a mismatch with `in_prev` on the same cycle. A broken hold under back-pressure shows up as a changed mask, or a lost or duplicated beat, at the next handshake. The reference model tracks every beat in order, so that change or loss is found there.

// File: rtl/ffm_pkg.sv
package ffm_pkg;
  typedef enum logic [1:0] {
    FFM_BEFORE = 2'b00,
    FFM_INCL   = 2'b01,
    FFM_ONLY   = 2'b10,
    FFM_RSVD   = 2'b11
  } ffm_mode_e;
endpackage

// File: rtl/ffm_prefix_or.sv
// Log-depth inclusive prefix-OR, plus the exclusive form shifted up by one.
module ffm_prefix_or #(
  parameter int W = 64
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] incl,
  output logic [W-1:0] excl
);
  localparam int LG = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0] lvl [0:LG];

  assign lvl[0] = din;

  for (genvar s = 0; s < LG; s++) begin : g_stage
    localparam int DIST = 1 << s;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= DIST) begin : g_or
        assign lvl[s+1][i] = lvl[s][i] | lvl[s][i-DIST];
      end else begin : g_pass
        assign lvl[s+1][i] = lvl[s][i];
      end
    end
  end

  assign incl = lvl[LG];
  assign excl = {incl[W-2:0], 1'b0};
endmodule

// File: rtl/ffm_mask_core.sv
// Combinational mask composition for the three find-first variants.
module ffm_mask_core
  import ffm_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] src,
  input  logic [W-1:0] act,
  input  logic [W-1:0] prev,
  input  ffm_mode_e    mode,
  output logic [W-1:0] mask
);
  logic [W-1:0] hits;
  logic [W-1:0] seen_incl;
  logic [W-1:0] seen_excl;
  logic [W-1:0] sel;

  assign hits = src & act;

  ffm_prefix_or #(.W(W)) u_scan (
    .din  (hits),
    .incl (seen_incl),
    .excl (seen_excl)
  );

  always_comb begin
    unique case (mode)
      FFM_BEFORE: sel = ~seen_incl;
      FFM_INCL:   sel = ~seen_excl;
      FFM_ONLY:   sel = seen_incl & ~seen_excl;
      default:    sel = '0;
    endcase
  end

  always_comb begin
    if (mode == FFM_RSVD) mask = '0;
    else                  mask = (act & sel) | (~act & prev);
  end
endmodule

// File: rtl/ffm_out_stage.sv
// Single register slice with valid/ready on both sides.
module ffm_out_stage #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take)     out_data  <= in_data;
    end
  end
endmodule

// File: rtl/ffm_mask_gen.sv
module ffm_mask_gen
  import ffm_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [XLEN-1:0] in_src,
  input  logic [XLEN-1:0] in_pred,
  input  logic            in_pred_en,
  input  logic [XLEN-1:0] in_prev,
  input  logic [1:0]      in_mode,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_mask
);
  logic [XLEN-1:0] act;
  logic [XLEN-1:0] comb_mask;

  assign act = in_pred_en ? in_pred : '1;

  ffm_mask_core #(.W(XLEN)) u_core (
    .src  (in_src),
    .act  (act),
    .prev (in_prev),
    .mode (ffm_mode_e'(in_mode)),
    .mask (comb_mask)
  );

  ffm_out_stage #(.W(XLEN)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (comb_mask),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_mask)
  );
endmodule

// File: rtl/ffm_mask_gen_chk.sv
module ffm_mask_gen_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [XLEN-1:0] in_src,
  input logic [XLEN-1:0] in_pred,
  input logic            in_pred_en,
  input logic [XLEN-1:0] in_prev,
  input logic [1:0]      in_mode,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_mask
);
  logic [XLEN-1:0] cap_act;
  logic [XLEN-1:0] cap_prev;
  logic [1:0]      cap_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_act  <= '0;
      cap_prev <= '0;
      cap_mode <= 2'b00;
    end else if (in_valid && in_ready) begin
      cap_act  <= in_pred_en ? in_pred : '1;
      cap_prev <= in_prev;
      cap_mode <= in_mode;
    end
  end

  // R10
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R8
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_mask)));

  // R5
  inactive_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_mode != 2'b11) |-> (((out_mask ^ cap_prev) & ~cap_act) == '0));

  // R4
  only_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_mode == 2'b10) |-> $onehot0(out_mask & cap_act));

  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_mode == 2'b11) |-> (out_mask == '0));

  logic unused_src;
  assign unused_src = ^in_src;
endmodule

bind ffm_mask_gen ffm_mask_gen_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_src     (in_src),
  .in_pred    (in_pred),
  .in_pred_en (in_pred_en),
  .in_prev    (in_prev),
  .in_mode    (in_mode),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_mask   (out_mask)
);

// File: tb/ffm_mask_gen_tb_top.sv
module ffm_mask_gen_tb_top;
  localparam int XLEN = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [XLEN-1:0] in_src = '0;
  logic [XLEN-1:0] in_pred = '0;
  logic            in_pred_en = 1'b0;
  logic [XLEN-1:0] in_prev = '0;
  logic [1:0]      in_mode = 2'b00;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic [XLEN-1:0] out_mask;

  int checks = 0;
  int errors = 0;
  logic prev_acc = 1'b0;
  logic [XLEN-1:0] exp_q[$];
  string           tag_q[$];

  always #5 clk = ~clk;

  ffm_mask_gen #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_pred(in_pred), .in_pred_en(in_pred_en),
    .in_prev(in_prev), .in_mode(in_mode), .out_valid(out_valid),
    .out_ready(out_ready), .out_mask(out_mask)
  );

  // Bit-serial reference scan, lowest index first.
  function automatic logic [XLEN-1:0] ref_mask(
    input logic [XLEN-1:0] src, input logic [XLEN-1:0] pred, input logic pen,
    input logic [XLEN-1:0] prev, input logic [1:0] mode);
    logic [XLEN-1:0] r = '0;
    bit found = 0;
    if (mode == 2'b11) return '0;
    for (int i = 0; i < XLEN; i++) begin
      if (pen && !pred[i]) r[i] = prev[i];
      else begin
        case (mode)
          2'b00:   r[i] = !found && !src[i];
          2'b01:   r[i] = !found;
          default: r[i] = !found && src[i];
        endcase
        if (src[i]) found = 1;
      end
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [1:0] mode, input logic pen);
    if (mode == 2'b11) return "R7";
    if (!pen)          return (mode == 2'b00) ? "R6/R1" : (mode == 2'b01) ? "R6/R3" : "R6/R4";
    return (mode == 2'b00) ? "R1/R5" : (mode == 2'b01) ? "R3/R5" : "R4/R5";
  endfunction

  task automatic check(input bit ok, input string tag, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, observe just after, account for the next rising edge.
  task automatic step(input logic v, input logic [XLEN-1:0] s, input logic [XLEN-1:0] p,
                      input logic pen, input logic [XLEN-1:0] pv, input logic [1:0] m,
                      input string tag, input logic ordy, output logic acc);
    logic cons;
    @(negedge clk);
    in_valid = v; in_src = s; in_pred = p; in_pred_en = pen; in_prev = pv; in_mode = m;
    out_ready = ordy;
    #1;
    if (prev_acc) check(out_valid === 1'b1, "R8", XLEN'(out_valid), XLEN'(1));
    check(in_ready === (!out_valid || out_ready), "R9", XLEN'(in_ready),
          XLEN'(!out_valid || out_ready));
    if (out_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R8", out_mask, '0);
      else check(out_mask === exp_q[0], tag_q[0], out_mask, exp_q[0]);
    end
    cons = out_valid && out_ready;
    acc  = v && in_ready;
    if (cons && exp_q.size() > 0) begin
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
    if (acc) begin
      exp_q.push_back(ref_mask(s, p, pen, pv, m));
      tag_q.push_back(tag);
    end
    prev_acc = acc;
  endtask

  task automatic send(input logic [XLEN-1:0] s, input logic [XLEN-1:0] p, input logic pen,
                      input logic [XLEN-1:0] pv, input logic [1:0] m, input string tag,
                      input bit rnd_ready);
    logic acc = 1'b0;
    while (!acc) step(1'b1, s, p, pen, pv, m, tag, rnd_ready ? ($urandom_range(0, 9) < 7) : 1'b1, acc);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R8: watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic acc;
    repeat (3) begin
      @(negedge clk);
      check(out_valid === 1'b0, "R10", XLEN'(out_valid), '0);
    end
    rst_n = 1'b1;

    // Directed cases (values written MSB first)
    send(8'b10010100, 8'h00, 1'b0, 8'h00, 2'b00, "R1", 1'b0);
    send(8'b00000000, 8'h00, 1'b0, 8'h00, 2'b00, "R2", 1'b0);
    send(8'b10010100, 8'hFF, 1'b1, 8'h00, 2'b01, "R3", 1'b0);
    send(8'b10010101, 8'h00, 1'b0, 8'h00, 2'b10, "R4", 1'b0);
    send(8'b10010100, 8'b11000011, 1'b1, 8'b00111100, 2'b00, "R5", 1'b0);
    send(8'b11010100, 8'b11000011, 1'b1, 8'b00000000, 2'b10, "R5", 1'b0);
    send(8'b00000000, 8'b00001111, 1'b1, 8'b10100000, 2'b01, "R3", 1'b0);
    send(8'b00000000, 8'b00111100, 1'b1, 8'hFF, 2'b10, "R4", 1'b0);
    send(8'b01011010, 8'h00, 1'b1, 8'hFF, 2'b11, "R7", 1'b0);
    send(8'b10000000, 8'b00001111, 1'b0, 8'h00, 2'b00, "R6", 1'b0);

    // Random traffic with back-pressure and idle gaps
    for (int k = 0; k < 600; k++) begin
      logic [XLEN-1:0] s = XLEN'($urandom) & XLEN'($urandom);
      logic [XLEN-1:0] p = XLEN'($urandom);
      logic pen = $urandom_range(0, 1);
      logic [1:0] m = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 4) == 0)
        step(1'b0, '0, '0, 1'b0, '0, 2'b00, "R9", $urandom_range(0, 1), acc);
      send(s, p, pen, XLEN'($urandom), m, tag_of(m, pen), 1'b1);
    end

    for (int k = 0; k < 4; k++) step(1'b0, '0, '0, 1'b0, '0, 2'b00, "R9", 1'b1, acc);
    check(exp_q.size() == 0, "R9", XLEN'(exp_q.size()), '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule